// File: doc/BRIEF.md
# Paired-Channel Handoff and Bus Arbiter

This block sits beside a four-channel DMA engine and does two jobs. It decides which channel owns the bus when several ask for it in the same cycle, and it links channels into fixed pairs so that one channel of a pair is re-armed as soon as its partner finishes. The pairs never change: channel 0 goes with channel 1, and channel 2 goes with channel 3. The bus can therefore move data without a gap while software refills the buffer that has just been drained.

Each pair has its own enable, so one pair can alternate while the other pair's channels run on their own or stay idle. Software has to give both channels of a linked pair the same repeat count. Their block sizes may differ. The block does not check either setting. A mode input selects how the winner is chosen. Under fixed priority the lowest requesting channel number wins. Under round robin the search starts just after the channel that was granted last, so that channel has the lowest priority on the next decision.

All pins are plain level or pulse control signals. No data passes through the block, so there is no valid/ready stream and no back-pressure. The burst-done input acts as the release for the grant that is currently held.

Top module: `dbuf_chain_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grant_o` and `arm_o` are all zero.
- R2: At most one bit of `grant_o` is set in any cycle.
- R3: A grant stays unchanged until `burst_done_i` is high in a cycle. It is zero in the following cycle. A new grant can appear no earlier than one cycle after that.
- R4: With `rr_mode_i` = 0 (fixed), when the bus is idle the lowest-numbered requesting channel gets the grant. `grant_o` bit n belongs to channel n.
- R5: With `rr_mode_i` = 1 (round robin), the search starts at the channel after the one most recently granted and wraps from 3 to 0. After reset the most recent grant counts as channel 3.
- R6: The grant is set in the cycle after the bus was idle and `req_i` was nonzero, and it only goes to a channel that was requesting in that cycle. If no channel requests, no grant is given.
- R7: When `pair_dbuf_en_i[0]` is 1, a `txn_done_i` pulse from channel 0 raises `arm_o[1]` in the next cycle, and a pulse from channel 1 raises `arm_o[0]`.
- R8: When `pair_dbuf_en_i[1]` is 1, a `txn_done_i` pulse from channel 2 raises `arm_o[3]` in the next cycle, and a pulse from channel 3 raises `arm_o[2]`.
- R9: A `txn_done_i` pulse on a channel whose pair has its enable at 0 raises no `arm_o` bit. Each pair's enable acts only on its own two channels.
- R10: Each `arm_o` bit is a single-cycle pulse for each cycle of partner `txn_done_i`. When several channels finish in the same cycle, all the matching handoffs are issued together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode_i | input | 1 | 0 = fixed priority, 1 = round robin |
| req_i | input | 4 | Per-channel bus request level |
| burst_done_i | input | 1 | Pulse: the burst of the granted channel has ended |
| txn_done_i | input | 4 | Per-channel transaction-complete pulse |
| pair_dbuf_en_i | input | 2 | Bit 0 links channels 0/1, bit 1 links channels 2/3 |
| grant_o | output | 4 | One-hot bus grant, zero when idle |
| arm_o | output | 4 | Pulse that enables the channel taking over |

## Verification
Arbitration is tried in fixed mode with all four channels requesting and with partial masks such as 1100 and 1010. This shows that the lowest index wins and that higher channels are still reached when the lower ones are quiet. Round robin is run with a full request mask over more than one full rotation, so that the wrap from channel 3 to 0 is seen. It is also run with sparse masks, where the search has to skip idle channels starting from the last winner. Handoff is tried with only pair 0 linked, with only pair 1 linked, and with both linked while several channels finish in the same cycle. These cases separate partner mapping from pair isolation.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int DBC_NCH = 4;

  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_RR    = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dbc_pick.sv
module dbc_pick #(
  parameter int NCH  = dbc_pkg::DBC_NCH,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic [NCH-1:0]  req_i,
  input  logic [IDXW-1:0] last_i,
  input  dbc_pkg::arb_mode_e mode_i,
  output logic [NCH-1:0]  win_o
);
  logic [IDXW-1:0] idx;
  logic            found;

  always_comb begin
    win_o = '0;
    found = 1'b0;
    idx   = '0;
    if (mode_i == dbc_pkg::ARB_RR) begin
      // walk from the channel after the last winner, wrapping
      for (int off = 1; off <= NCH; off++) begin
        idx = last_i + IDXW'(off);
        if (!found && req_i[idx]) begin
          win_o[idx] = 1'b1;
          found      = 1'b1;
        end
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (!found && req_i[i]) begin
          win_o[i] = 1'b1;
          found    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbc_grant.sv
module dbc_grant #(
  parameter int NCH  = dbc_pkg::DBC_NCH,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req_i,
  input  logic [NCH-1:0]  win_i,
  input  logic            burst_done_i,
  output logic [NCH-1:0]  grant_o,
  output logic [IDXW-1:0] last_o
);
  logic [NCH-1:0]  grant_q;
  logic [IDXW-1:0] last_q;
  logic [IDXW-1:0] win_idx;
  logic            busy;

  assign busy = |grant_q;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (win_i[i]) win_idx = IDXW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= IDXW'(NCH - 1);
    end else if (busy) begin
      if (burst_done_i) grant_q <= '0;
    end else if (|win_i) begin
      grant_q <= win_i;
      last_q  <= win_idx;
    end
  end

  assign grant_o = grant_q;
  assign last_o  = last_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q)); // R2
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !burst_done_i) |=> (grant_q == $past(grant_q))); // R3
  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && burst_done_i) |=> (grant_q == '0)); // R3
  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_i == '0) |=> (grant_q == '0)); // R6
  AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_i != '0) |=> ((grant_q & $past(req_i)) != '0)); // R6
endmodule

// File: rtl/dbc_pair_link.sv
module dbc_pair_link #(
  parameter int NCH   = dbc_pkg::DBC_NCH,
  parameter int NPAIR = NCH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   txn_done_i,
  input  logic [NPAIR-1:0] pair_en_i,
  output logic [NCH-1:0]   arm_o
);
  logic [NCH-1:0] arm_q;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int EVN = 2 * p;
    localparam int ODD = 2 * p + 1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        arm_q[EVN] <= 1'b0;
        arm_q[ODD] <= 1'b0;
      end else begin
        arm_q[ODD] <= pair_en_i[p] & txn_done_i[EVN];
        arm_q[EVN] <= pair_en_i[p] & txn_done_i[ODD];
      end
    end

    AST_ARM_ODD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      arm_q[ODD] |-> $past(txn_done_i[EVN] && pair_en_i[p])); // R7
    AST_ARM_EVN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      arm_q[EVN] |-> $past(txn_done_i[ODD] && pair_en_i[p])); // R8
    AST_ARM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_en_i[p] |=> (arm_q[EVN] == 1'b0 && arm_q[ODD] == 1'b0)); // R9
    AST_ARM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_en_i[p] && txn_done_i[EVN]) |=> arm_q[ODD]); // R10
  end

  assign arm_o = arm_q;
endmodule

// File: rtl/dbuf_chain_ctrl.sv
module dbuf_chain_ctrl #(
  parameter int NCH   = dbc_pkg::DBC_NCH,
  parameter int NPAIR = NCH / 2,
  parameter int IDXW  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rr_mode_i,
  input  logic [NCH-1:0]   req_i,
  input  logic             burst_done_i,
  input  logic [NCH-1:0]   txn_done_i,
  input  logic [NPAIR-1:0] pair_dbuf_en_i,
  output logic [NCH-1:0]   grant_o,
  output logic [NCH-1:0]   arm_o
);
  import dbc_pkg::*;

  arb_mode_e       mode;
  logic [NCH-1:0]  win;
  logic [IDXW-1:0] last;
  logic [NCH-1:0]  lower_mask;

  assign mode = rr_mode_i ? ARB_RR : ARB_FIXED;

  dbc_pick #(.NCH(NCH), .IDXW(IDXW)) u_pick (
    .req_i  (req_i),
    .last_i (last),
    .mode_i (mode),
    .win_o  (win)
  );

  dbc_grant #(.NCH(NCH), .IDXW(IDXW)) u_grant (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .win_i        (win),
    .burst_done_i (burst_done_i),
    .grant_o      (grant_o),
    .last_o       (last)
  );

  dbc_pair_link #(.NCH(NCH), .NPAIR(NPAIR)) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_done_i (txn_done_i),
    .pair_en_i  (pair_dbuf_en_i),
    .arm_o      (arm_o)
  );

  assign lower_mask = grant_o - NCH'(1);

  AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && $past(grant_o) == '0 && $past(rr_mode_i) == 1'b0)
      |-> (($past(req_i) & lower_mask) == '0)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (grant_o == '0 && arm_o == '0)); // R1
endmodule

// File: tb/dbuf_chain_ctrl_bench.sv
module dbuf_chain_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rr_mode_i = 1'b0;
  logic [3:0] req_i = '0;
  logic       burst_done_i = 1'b0;
  logic [3:0] txn_done_i = '0;
  logic [1:0] pair_dbuf_en_i = '0;
  logic [3:0] grant_o;
  logic [3:0] arm_o;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_q[$];
  logic [3:0] grant_prev = '0;

  always #4 clk = ~clk;

  dbuf_chain_ctrl u_dbuf_chain_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .rr_mode_i      (rr_mode_i),
    .req_i          (req_i),
    .burst_done_i   (burst_done_i),
    .txn_done_i     (txn_done_i),
    .pair_dbuf_en_i (pair_dbuf_en_i),
    .grant_o        (grant_o),
    .arm_o          (arm_o)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: compares each newly raised grant against the scoreboard
  always @(negedge clk) begin
    if (rst_n && grant_o != '0 && grant_prev == '0) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected grant", grant_o, 4'b0000);
      end else begin
        check(rr_mode_i ? "R5 rr winner" : "R4 fixed winner",
              grant_o, 4'(1) << exp_q.pop_front());
      end
    end
    grant_prev = grant_o;
  end

  task automatic burst(input logic [3:0] reqs, input int exp);
    exp_q.push_back(exp);
    @(negedge clk); req_i = reqs;
    @(negedge clk);
    @(negedge clk); check("R3 grant held", grant_o, 4'(1) << exp);
    burst_done_i = 1'b1;
    @(negedge clk); check("R3 grant released", grant_o, 4'b0000);
    burst_done_i = 1'b0; req_i = '0;
  endtask

  task automatic handoff(input logic [1:0] en, input logic [3:0] done, input logic [3:0] exp, input string tag);
    @(negedge clk); pair_dbuf_en_i = en; txn_done_i = done;
    @(negedge clk); check(tag, arm_o, exp);
    txn_done_i = '0;
    @(negedge clk); check("R10 arm is one pulse", arm_o, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 grant in reset", grant_o, 4'b0000);
    check("R1 arm in reset", arm_o, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 grant after reset", grant_o, 4'b0000);
    @(negedge clk);
    check("R6 no request no grant", grant_o, 4'b0000);

    rr_mode_i = 1'b0;
    burst(4'b1111, 0);
    burst(4'b1111, 0);
    burst(4'b1100, 2);
    burst(4'b1010, 1);
    burst(4'b1000, 3);

    rr_mode_i = 1'b1;
    burst(4'b1111, 0);
    burst(4'b1111, 1);
    burst(4'b1111, 2);
    burst(4'b1111, 3);
    burst(4'b1111, 0);
    burst(4'b1010, 1);
    burst(4'b1010, 3);
    burst(4'b0101, 0);
    burst(4'b0101, 2);

    handoff(2'b01, 4'b0001, 4'b0010, "R7 ch0 arms ch1");
    handoff(2'b01, 4'b0010, 4'b0001, "R7 ch1 arms ch0");
    handoff(2'b01, 4'b0100, 4'b0000, "R9 pair1 off");
    handoff(2'b10, 4'b1000, 4'b0100, "R8 ch3 arms ch2");
    handoff(2'b10, 4'b0100, 4'b1000, "R8 ch2 arms ch3");
    handoff(2'b10, 4'b0011, 4'b0000, "R9 pair0 off");
    handoff(2'b11, 4'b1111, 4'b1111, "R10 all handoffs together");
    handoff(2'b11, 4'b0101, 4'b1010, "R10 two handoffs");

    @(negedge clk);
    check("R6 leftover grants", 4'(exp_q.size()), 4'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule